// File: doc/BRIEF.md
# Demand-Paced DMA FIFO Bridge

This block places two FIFOs between a host DMA engine and user logic. On the host-to-card path the host pushes 32-bit words into an inbound FIFO, and user logic drains that FIFO. On the card-to-host path user logic fills an outbound FIFO, and the host pops from it. Each direction has a byte counter. The host loads the counter through a small register port before it starts the matching DMA. The block asserts a per-direction demand request only while that counter is nonzero and the FIFO on that path can move a word. A full inbound FIFO or an empty outbound FIFO therefore stalls the host until user logic catches up.

Each direction is run by a two-state sequencer with the states `CH_IDLE` (counter zero) and `CH_ARMED` (counter nonzero). The transition *arm* goes from `CH_IDLE` to `CH_ARMED` when a nonzero value is loaded. The transition *disarm* returns to `CH_IDLE` when zero is loaded. The transition *drain* also returns to `CH_IDLE` when the last word of the count moves. Register accesses are answered by a second two-state machine with the states `RG_IDLE` and `RG_ACK`. The transition *strobe* enters `RG_ACK` on any read or write. The transition *release* returns to `RG_IDLE` one cycle later when no new strobe arrives. The host reads a counter back to poll for completion.

Top module: `dmab_bridge`

## Requirements
- R1: After reset both counters read 0, both FIFOs are empty, `h2c_req` and `c2h_req` are low, `usr_rx_empty` is high, `usr_tx_full` is low, `reg_ack` is low and `reg_rdata` is 0.
- R2: A register write to byte address 0x040080 loads the host-to-card counter, and a write to 0x0400C0 loads the card-to-host counter. A write to any other address changes neither counter.
- R3: Every cycle with `reg_wr` or `reg_rd` high is followed by exactly one cycle with `reg_ack` high. After a read, `reg_rdata` holds the value the addressed counter had in the read cycle, or 0 for any other address, and it keeps that value until the next read.
- R4: `h2c_req` is high exactly when the host-to-card counter is nonzero and the inbound FIFO holds fewer than 512 words.
- R5: A cycle with `h2c_wr` and `h2c_req` both high appends `h2c_data` to the inbound FIFO and lowers the counter by 4, or to 0 if the counter is 4 or less. `h2c_wr` while `h2c_req` is low is ignored.
- R6: `c2h_req` is high exactly when the card-to-host counter is nonzero and the outbound FIFO is not empty. `c2h_data` always shows the oldest outbound word.
- R7: A cycle with `c2h_rd` and `c2h_req` both high removes the oldest outbound word and lowers the counter by 4, or to 0 if the counter is 4 or less. `c2h_rd` while `c2h_req` is low is ignored.
- R8: Both FIFOs are 512 words deep and keep first-in-first-out order, and `usr_rx_data` shows the oldest inbound word. A user pop (`usr_rx_pop`) while `usr_rx_empty` is high is ignored, and a user push (`usr_tx_push`) while `usr_tx_full` is high is ignored.
- R9: When a counter write and a word transfer on the same direction fall in one cycle, the written value is the new count and the transfer's decrement is dropped. The word itself still moves.
- R10: A push and a pop on the same FIFO in one cycle, with the FIFO neither full nor empty, both take effect, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 24 | Register byte address |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value |
| reg_ack | output | 1 | Register access acknowledge |
| h2c_req | output | 1 | Host-to-card demand request |
| h2c_wr | input | 1 | Host-to-card word strobe |
| h2c_data | input | 32 | Host-to-card word |
| c2h_req | output | 1 | Card-to-host demand request |
| c2h_rd | input | 1 | Card-to-host word strobe |
| c2h_data | output | 32 | Card-to-host word (oldest outbound) |
| usr_rx_pop | input | 1 | User pop from inbound FIFO |
| usr_rx_data | output | 32 | Oldest inbound word |
| usr_rx_empty | output | 1 | Inbound FIFO empty |
| usr_tx_push | input | 1 | User push to outbound FIFO |
| usr_tx_data | input | 32 | Word for outbound FIFO |
| usr_tx_full | output | 1 | Outbound FIFO full |

## Verification
Two collisions matter most. The first is a host transfer and a user access hitting the same FIFO in one cycle. The second is a counter reload landing in the same cycle as a word transfer. The bench provokes the first by holding the inbound FIFO one word short of full while the user pops and the host pushes together. It also mixes random host and user strobes on both paths over long runs. It provokes the second by writing a new count while `c2h_rd` pops a word. In both cases a queue-based reference model, advanced edge by edge, predicts occupancy, head words, demand and the counter readback. The bench compares these against the ports every cycle.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
    typedef enum logic {CH_IDLE, CH_ARMED} ch_state_e;
    typedef enum logic {RG_IDLE, RG_ACK} rg_state_e;
endpackage

// File: rtl/dmab_fifo.sv
module dmab_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 512
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int NW = AW + 1;
    localparam logic [NW-1:0] FULL_V = NW'(DEPTH);
    localparam logic [AW-1:0] LAST_V = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [NW-1:0] level;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == FULL_V);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_V) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST_V) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R8
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> full);
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty);
    // R10
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(level));
endmodule

// File: rtl/dmab_chan.sv
module dmab_chan
    import dmab_pkg::*;
#(
    parameter int CW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          ready,
    input  logic          strobe,
    output logic          req,
    output logic          move,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] STEP_V = CW'(STEP);

    ch_state_e state, state_nx;
    logic      last_word;

    assign last_word = (count <= STEP_V);

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE:  if (load && load_val != '0) state_nx = CH_ARMED;
            CH_ARMED: begin
                if (load) begin
                    if (load_val == '0) state_nx = CH_IDLE;
                end else if (move && last_word) begin
                    state_nx = CH_IDLE;
                end
            end
            default:  state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (move)  count <= last_word ? '0 : count - STEP_V;
    end

    always_comb begin
        req  = (state == CH_ARMED) && ready;
        move = req && strobe;
    end

    // R4
    req_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (count != '0));
    // R6
    req_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !req);
    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (move && !load) |=> (count == (($past(count) <= STEP_V) ? '0 : $past(count) - STEP_V)));
    // R9
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/dmab_bridge.sv
module dmab_bridge
    import dmab_pkg::*;
#(
    parameter int              DW       = 32,
    parameter int              DEPTH    = 512,
    parameter int              AW       = 24,
    parameter logic [AW-1:0]   ADDR_H2C = 24'h040080,
    parameter logic [AW-1:0]   ADDR_C2H = 24'h0400C0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_ack,
    output logic          h2c_req,
    input  logic          h2c_wr,
    input  logic [DW-1:0] h2c_data,
    output logic          c2h_req,
    input  logic          c2h_rd,
    output logic [DW-1:0] c2h_data,
    input  logic          usr_rx_pop,
    output logic [DW-1:0] usr_rx_data,
    output logic          usr_rx_empty,
    input  logic          usr_tx_push,
    input  logic [DW-1:0] usr_tx_data,
    output logic          usr_tx_full
);
    localparam int STEP = DW / 8;

    logic          rx_full, tx_empty;
    logic          h2c_move, c2h_move;
    logic [DW-1:0] h2c_cnt, c2h_cnt;
    logic          ld_h2c, ld_c2h;

    assign ld_h2c = reg_wr && (reg_addr == ADDR_H2C);
    assign ld_c2h = reg_wr && (reg_addr == ADDR_C2H);

    dmab_chan #(.CW(DW), .STEP(STEP)) u_chan_h2c (
        .clk(clk), .rst_n(rst_n), .load(ld_h2c), .load_val(reg_wdata),
        .ready(!rx_full), .strobe(h2c_wr), .req(h2c_req), .move(h2c_move),
        .count(h2c_cnt)
    );

    dmab_chan #(.CW(DW), .STEP(STEP)) u_chan_c2h (
        .clk(clk), .rst_n(rst_n), .load(ld_c2h), .load_val(reg_wdata),
        .ready(!tx_empty), .strobe(c2h_rd), .req(c2h_req), .move(c2h_move),
        .count(c2h_cnt)
    );

    dmab_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(h2c_move), .push_data(h2c_data),
        .pop(usr_rx_pop), .head(usr_rx_data), .empty(usr_rx_empty), .full(rx_full)
    );

    dmab_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(usr_tx_push), .push_data(usr_tx_data),
        .pop(c2h_move), .head(c2h_data), .empty(tx_empty), .full(usr_tx_full)
    );

    rg_state_e rg_state, rg_nx;
    logic      strobe_any;

    assign strobe_any = reg_wr || reg_rd;

    always_comb begin
        rg_nx = rg_state;
        unique case (rg_state)
            RG_IDLE: if (strobe_any)  rg_nx = RG_ACK;
            RG_ACK:  if (!strobe_any) rg_nx = RG_IDLE;
            default: rg_nx = RG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_state <= RG_IDLE;
        else        rg_state <= rg_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (reg_addr == ADDR_H2C)      reg_rdata <= h2c_cnt;
            else if (reg_addr == ADDR_C2H) reg_rdata <= c2h_cnt;
            else                           reg_rdata <= '0;
        end
    end

    assign reg_ack = (rg_state == RG_ACK);

    // R3
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_any |=> reg_ack);
    // R3
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_any |=> !reg_ack);
    // R5
    h2c_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h2c_wr && !h2c_req && !usr_rx_pop) |=> $stable(usr_rx_empty));
endmodule

// File: tb/dmab_bridge_test.sv
module dmab_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam logic [23:0] A_H2C = 24'h040080;
    localparam logic [23:0] A_C2H = 24'h0400C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [23:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ack;
    logic        h2c_req, h2c_wr = 0;
    logic [31:0] h2c_data = '0;
    logic        c2h_req, c2h_rd = 0;
    logic [31:0] c2h_data;
    logic        usr_rx_pop = 0;
    logic [31:0] usr_rx_data;
    logic        usr_rx_empty;
    logic        usr_tx_push = 0;
    logic [31:0] usr_tx_data = '0;
    logic        usr_tx_full;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] q_rx[$];
    logic [31:0] q_tx[$];
    logic [31:0] m_h2c = 0, m_c2h = 0, m_rdata = 0;
    logic        m_ack = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmab_bridge uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .h2c_req(h2c_req), .h2c_wr(h2c_wr), .h2c_data(h2c_data),
        .c2h_req(c2h_req), .c2h_rd(c2h_rd), .c2h_data(c2h_data),
        .usr_rx_pop(usr_rx_pop), .usr_rx_data(usr_rx_data), .usr_rx_empty(usr_rx_empty),
        .usr_tx_push(usr_tx_push), .usr_tx_data(usr_tx_data), .usr_tx_full(usr_tx_full)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] dec(logic [31:0] c);
        return (c <= 4) ? 32'd0 : c - 32'd4;
    endfunction

    task automatic compare_all();
        chk("R4 h2c_req", 32'(h2c_req), 32'((m_h2c != 0) && (q_rx.size() < DEPTH)));
        chk("R6 c2h_req", 32'(c2h_req), 32'((m_c2h != 0) && (q_tx.size() != 0)));
        chk("R8 rx_empty", 32'(usr_rx_empty), 32'(q_rx.size() == 0));
        chk("R8 tx_full", 32'(usr_tx_full), 32'(q_tx.size() == DEPTH));
        chk("R3 ack", 32'(reg_ack), 32'(m_ack));
        chk("R3 rdata", reg_rdata, m_rdata);
        if (q_rx.size() != 0) chk("R8 rx head", usr_rx_data, q_rx[0]);
        if (q_tx.size() != 0) chk("R6 c2h head", c2h_data, q_tx[0]);
    endtask

    task automatic tick();
        bit dq0, dq1, mv0, mv1, upop, upush, strobe;
        logic [31:0] nrd;
        dq0    = (m_h2c != 0) && (q_rx.size() < DEPTH);
        dq1    = (m_c2h != 0) && (q_tx.size() != 0);
        mv0    = dq0 && h2c_wr;
        mv1    = dq1 && c2h_rd;
        upop   = usr_rx_pop && (q_rx.size() != 0);
        upush  = usr_tx_push && (q_tx.size() < DEPTH);
        strobe = reg_wr || reg_rd;
        nrd    = m_rdata;
        if (reg_rd) nrd = (reg_addr == A_H2C) ? m_h2c : (reg_addr == A_C2H) ? m_c2h : 32'd0;
        @(posedge clk);
        if (upop) void'(q_rx.pop_front());
        if (mv0)  q_rx.push_back(h2c_data);
        if (mv1)  void'(q_tx.pop_front());
        if (upush) q_tx.push_back(usr_tx_data);
        if (reg_wr && reg_addr == A_H2C) m_h2c = reg_wdata;
        else if (mv0)                    m_h2c = dec(m_h2c);
        if (reg_wr && reg_addr == A_C2H) m_c2h = reg_wdata;
        else if (mv1)                    m_c2h = dec(m_c2h);
        m_ack   = strobe;
        m_rdata = nrd;
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_reg(logic [23:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd_reg(logic [23:0] a, output logic [31:0] v);
        reg_rd = 1; reg_addr = a;
        tick();
        reg_rd = 0;
        v = reg_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 h2c_req", 32'(h2c_req), 0);
        chk("R1 c2h_req", 32'(c2h_req), 0);
        chk("R1 rx_empty", 32'(usr_rx_empty), 1);
        chk("R1 tx_full", 32'(usr_tx_full), 0);
        chk("R1 rdata", reg_rdata, 0);
        rd_reg(A_H2C, v); chk("R1 h2c count", v, 0);
        rd_reg(A_C2H, v); chk("R1 c2h count", v, 0);

        // R2 loads and stray addresses
        wr_reg(A_H2C, 32'd40);
        wr_reg(24'h040084, 32'd99);
        wr_reg(24'h040040, 32'd77);
        rd_reg(A_H2C, v); chk("R2 h2c load", v, 40);
        rd_reg(24'h040084, v); chk("R3 stray read", v, 0);
        rd_reg(A_C2H, v); chk("R2 c2h untouched", v, 0);

        // R5 host-to-card traffic with random user pops
        for (int i = 0; i < 60; i++) begin
            h2c_wr = 1'($urandom); h2c_data = $urandom; usr_rx_pop = 1'($urandom);
            tick();
        end
        h2c_wr = 0; usr_rx_pop = 0;
        rd_reg(A_H2C, v); chk("R5 h2c drained", v, 0);
        h2c_wr = 1; h2c_data = 32'hDEAD0001; tick(); h2c_wr = 0;
        chk("R5 ignored strobe", 32'(h2c_req), 0);
        repeat (20) begin usr_rx_pop = 1; tick(); end
        usr_rx_pop = 0;
        chk("R8 rx empty after drain", 32'(usr_rx_empty), 1);

        // R4 stall on full inbound FIFO
        wr_reg(A_H2C, 32'd2400);
        for (int i = 0; i < 520; i++) begin
            h2c_wr = 1; h2c_data = 32'h1000_0000 + i; tick();
        end
        h2c_wr = 0;
        chk("R4 req low when full", 32'(h2c_req), 0);
        rd_reg(A_H2C, v); chk("R5 stalled count", v, 2400 - 4 * DEPTH);
        usr_rx_pop = 1; tick();
        // R10 simultaneous push and pop
        h2c_wr = 1; h2c_data = 32'hCAFE0010; tick();
        usr_rx_pop = 0; h2c_wr = 0;
        chk("R10 occupancy kept", 32'(h2c_req), 1);
        rd_reg(A_H2C, v); chk("R10 count", v, 2400 - 4 * DEPTH - 4);
        repeat (520) begin usr_rx_pop = 1; tick(); end
        usr_rx_pop = 0;
        chk("R8 pop on empty ignored", 32'(usr_rx_empty), 1);

        // R8 fill outbound FIFO beyond depth
        for (int i = 0; i < 520; i++) begin
            usr_tx_push = 1; usr_tx_data = 32'h2000_0000 + i; tick();
        end
        usr_tx_push = 0;
        chk("R8 tx full", 32'(usr_tx_full), 1);
        chk("R6 req low with zero count", 32'(c2h_req), 0);

        // R7 odd byte count: 6 -> 2 -> 0
        wr_reg(A_C2H, 32'd6);
        repeat (5) begin c2h_rd = 1; tick(); end
        c2h_rd = 0;
        rd_reg(A_C2H, v); chk("R7 c2h drained", v, 0);
        chk("R7 head after two pops", c2h_data, 32'h2000_0002);

        // R7 random card-to-host traffic
        wr_reg(A_C2H, 32'd2400);
        for (int i = 0; i < 1500; i++) begin
            c2h_rd = 1'($urandom); usr_tx_push = 1'($urandom); usr_tx_data = $urandom;
            tick();
        end
        c2h_rd = 0; usr_tx_push = 0;

        // R9 reload collides with a transfer
        wr_reg(A_C2H, 32'd100);
        usr_tx_push = 1; usr_tx_data = 32'h3000_0001; tick(); usr_tx_push = 0;
        reg_wr = 1; reg_addr = A_C2H; reg_wdata = 32'd20; c2h_rd = 1;
        tick();
        reg_wr = 0; c2h_rd = 0;
        rd_reg(A_C2H, v); chk("R9 load wins", v, 20);

        // mixed random traffic on both paths
        for (int i = 0; i < 3000; i++) begin
            h2c_wr = 1'($urandom); h2c_data = $urandom;
            c2h_rd = 1'($urandom); usr_rx_pop = 1'($urandom);
            usr_tx_push = 1'($urandom); usr_tx_data = $urandom;
            if (($urandom % 97) == 0) begin
                reg_wr = 1; reg_addr = (i % 2 == 0) ? A_H2C : A_C2H;
                reg_wdata = $urandom % 400;
            end else if (($urandom % 89) == 0) begin
                reg_rd = 1; reg_addr = (i % 2 == 0) ? A_C2H : A_H2C;
            end
            tick();
            reg_wr = 0; reg_rd = 0;
        end
        h2c_wr = 0; c2h_rd = 0; usr_rx_pop = 0; usr_tx_push = 0;
        tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule